// File: doc/BRIEF.md
# Pin Configuration Register Bank

This block holds one 32-bit configuration word for each of 32 pins and drives the static pad controls from the lower 16 bits of each word. Those controls are pull selection, pull strength, slew, passive filter, open drain, two drive-strength bits, a 4-bit function select, input-buffer enable, input inversion and a lock. The upper 16 bits of each word are stored and passed out unchanged to a neighbouring block, which owns the meaning of those bits.

Software reaches the bank through a simple word-addressed register bus. A write completes in one cycle and reads are combinational. Two broadcast registers let one write load the same lower-half value into any subset of a pin group. One register covers pins 0–15 and the other covers pins 16–31. Setting a pin's lock bit freezes its lower half until reset.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset every pin word reads 0 and every pad-control output is 0.
- R2: A bus write to word address p (0–31) stores wdata[31:16] in the upper half and wdata[15:0] in the lower half of pin p, provided the pin is unlocked. A read of address p returns the stored word.
- R3: Each pin's pad outputs follow its lower half. Bits [1:0] select the pull: 0 means none, 2 means down and 3 means up. The remaining fields are: bit 2 pull strength, bit 3 slew, bit 4 passive filter, bit 5 open drain, bit 6 drive strength, bit 7 double drive, bits [11:8] function select (0 means analog/disabled, 1 means GPIO), bit 12 input-buffer enable, bit 13 input invert and bit 15 lock. The upper half appears on the pin's 16-bit slice of `pin_hi`.
- R4: A write to address 32 loads wdata[15:0] into the lower half of each unlocked pin i (0–15) whose mask bit wdata[16+i] is 1. Other pins and all upper halves are unchanged.
- R5: A write to address 33 loads wdata[15:0] into the lower half of each unlocked pin 16+i whose mask bit wdata[16+i] is 1. Other pins and all upper halves are unchanged.
- R6: While a pin's lock bit (bit 15) is 1, direct writes and broadcast writes leave its lower half unchanged.
- R7: A direct write to a locked pin still updates that pin's upper half.
- R8: Once set, a lock bit stays 1 until reset.
- R9: Addresses 32 and above read as 0. Writes to addresses 34 and above change nothing.
- R10: Bit 14 of every pin word reads as 0, whatever was written to it.
- R11: In a cycle without a write, no stored value and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pull_sel | output | 64 | 2-bit pull select per pin |
| pull_strong | output | 32 | Pull strength per pin |
| slew_slow | output | 32 | Slew select per pin |
| filt_en | output | 32 | Passive filter per pin |
| odrain_en | output | 32 | Open drain per pin |
| drive_hi | output | 32 | Drive strength per pin |
| drive_dbl | output | 32 | Double drive per pin |
| func_sel | output | 128 | 4-bit function select per pin |
| ibuf_en | output | 32 | Input buffer enable per pin |
| in_inv | output | 32 | Input invert per pin |
| locked | output | 32 | Lock state per pin |
| pin_hi | output | 512 | Upper half of each pin word |

## Verification
The hardest case to reach is a single broadcast write whose mask covers both locked and unlocked pins of the same group, because locks appear only rarely under random data. The bench covers it with a directed test. It locks one pin, sends a broadcast to every pin of that group, and confirms that only the locked pin keeps its old value. Random writes set the lock bit with low probability, so mixed-lock broadcasts also arise later in the run. All state is compared against a model word for every pin.

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [2*NPINS-1:0]   pull_sel,
  output logic [NPINS-1:0]     pull_strong,
  output logic [NPINS-1:0]     slew_slow,
  output logic [NPINS-1:0]     filt_en,
  output logic [NPINS-1:0]     odrain_en,
  output logic [NPINS-1:0]     drive_hi,
  output logic [NPINS-1:0]     drive_dbl,
  output logic [4*NPINS-1:0]   func_sel,
  output logic [NPINS-1:0]     ibuf_en,
  output logic [NPINS-1:0]     in_inv,
  output logic [NPINS-1:0]     locked,
  output logic [16*NPINS-1:0]  pin_hi
);
  localparam int HALF = NPINS / 2;
  localparam logic [AW-1:0] GLO_ADDR = AW'(NPINS);
  localparam logic [AW-1:0] GHI_ADDR = AW'(NPINS + 1);
  localparam logic [15:0] KEEP = 16'hBFFF;

  logic [15:0] lo_q [NPINS];
  logic [15:0] hi_q [NPINS];

  wire glo_wr = bus_we && (bus_addr == GLO_ADDR);
  wire ghi_wr = bus_we && (bus_addr == GHI_ADDR);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int MB = (p < HALF) ? p : p - HALF;
    wire direct = bus_we && (bus_addr == AW'(p));
    wire gsel   = ((p < HALF) ? glo_wr : ghi_wr) && bus_wdata[16+MB];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[p] <= '0;
        hi_q[p] <= '0;
      end else begin
        if ((direct || gsel) && !lo_q[p][15]) lo_q[p] <= bus_wdata[15:0] & KEEP;
        if (direct) hi_q[p] <= bus_wdata[31:16];
      end
    end

    assign pull_sel[2*p +: 2] = lo_q[p][1:0];
    assign pull_strong[p]     = lo_q[p][2];
    assign slew_slow[p]       = lo_q[p][3];
    assign filt_en[p]         = lo_q[p][4];
    assign odrain_en[p]       = lo_q[p][5];
    assign drive_hi[p]        = lo_q[p][6];
    assign drive_dbl[p]       = lo_q[p][7];
    assign func_sel[4*p +: 4] = lo_q[p][11:8];
    assign ibuf_en[p]         = lo_q[p][12];
    assign in_inv[p]          = lo_q[p][13];
    assign locked[p]          = lo_q[p][15];
    assign pin_hi[16*p +: 16] = hi_q[p];
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPINS; p++)
      if (bus_addr == AW'(p)) bus_rdata = {hi_q[p], lo_q[p]};
  end
endmodule

// File: rtl/pin_ctrl_bank_chk.sv
module pin_ctrl_bank_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [NPINS-1:0]    locked,
  input logic [4*NPINS-1:0]  func_sel,
  input logic [2*NPINS-1:0]  pull_sel
);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked & $past(locked)) == $past(locked));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> ($stable(locked) && $stable(func_sel) && $stable(pull_sel)));

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < AW'(NPINS)) |-> !bus_rdata[14]);

  p_glob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= AW'(NPINS)) |-> (bus_rdata == 32'h0));

  for (genvar p = 0; p < NPINS; p++) begin : g_lk
    p_locked_func_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked[p]) |-> ($stable(func_sel[4*p +: 4]) && $stable(pull_sel[2*p +: 2])));
  end
endmodule

bind pin_ctrl_bank pin_ctrl_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .locked(locked), .func_sel(func_sel), .pull_sel(pull_sel)
);

// File: tb/pin_ctrl_bank_tb.sv
module pin_ctrl_bank_tb;
  localparam int N  = 32;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2*N-1:0] pull_sel;
  logic [N-1:0] pull_strong, slew_slow, filt_en, odrain_en, drive_hi, drive_dbl;
  logic [4*N-1:0] func_sel;
  logic [N-1:0] ibuf_en, in_inv, locked;
  logic [16*N-1:0] pin_hi;

  logic [31:0] model [N];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_ctrl_bank #(.NPINS(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .pull_sel(pull_sel), .pull_strong(pull_strong),
    .slew_slow(slew_slow), .filt_en(filt_en), .odrain_en(odrain_en),
    .drive_hi(drive_hi), .drive_dbl(drive_dbl), .func_sel(func_sel),
    .ibuf_en(ibuf_en), .in_inv(in_inv), .locked(locked), .pin_hi(pin_hi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pads(int i);
    return {pin_hi[16*i +: 16], locked[i], 1'b0, in_inv[i], ibuf_en[i],
            func_sel[4*i +: 4], drive_dbl[i], drive_hi[i], odrain_en[i],
            filt_en[i], slew_slow[i], pull_strong[i], pull_sel[2*i +: 2]};
  endfunction

  task automatic model_wr(int a, logic [31:0] d);
    if (a < N) begin
      if (!model[a][15]) model[a][15:0] = d[15:0] & 16'hBFFF;
      model[a][31:16] = d[31:16];
    end else if (a == N || a == N + 1) begin
      for (int i = 0; i < N / 2; i++) begin
        int p = (a == N) ? i : i + N / 2;
        if (d[16+i] && !model[p][15]) model[p][15:0] = d[15:0] & 16'hBFFF;
      end
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 0;
    model_wr(a, d);
  endtask

  task automatic scan(string req);
    for (int i = 0; i < N + 3; i++) begin
      @(negedge clk);
      addr = AW'(i);
      #1;
      if (i < N) begin
        chk({req, " read"}, rdata, model[i]);
        chk({req, " pads"}, pads(i), model[i]);
      end else begin
        chk({req, " R9 read"}, rdata, 32'h0);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) model[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    scan("R1");

    wr(3, 32'hABCD_4F5A);
    scan("R2 R10");
    @(negedge clk); addr = 3; #1;
    chk("R10 bit14", {31'h0, rdata[14]}, 32'h0);

    wr(5, 32'h0000_0103);
    @(negedge clk); #1;
    chk("R3 pull up", {30'h0, pull_sel[11:10]}, 32'h3);
    chk("R3 gpio", {28'h0, func_sel[23:20]}, 32'h1);
    wr(5, 32'h0000_3052);
    @(negedge clk); #1;
    chk("R3 pull down", {30'h0, pull_sel[11:10]}, 32'h2);
    chk("R3 analog", {28'h0, func_sel[23:20]}, 32'h0);
    chk("R3 ibuf", {31'h0, ibuf_en[5]}, 32'h1);
    chk("R3 inv", {31'h0, in_inv[5]}, 32'h1);
    chk("R3 odrain", {31'h0, odrain_en[5]}, 32'h0);
    chk("R3 filt", {31'h0, filt_en[5]}, 32'h1);

    wr(N, {16'h8005, 16'h0212});
    scan("R4");
    wr(N + 1, {16'h0003, 16'h1302});
    scan("R5");

    wr(7, 32'h0000_8301);
    wr(7, 32'h5555_0000);
    scan("R7");
    wr(N, {16'hFFFF, 16'h0004});
    scan("R6");
    wr(7, 32'h0000_0000);
    @(negedge clk); #1;
    chk("R8 lock stays", {31'h0, locked[7]}, 32'h1);

    wr(N + 2, 32'hFFFF_FFFF);
    wr(60, 32'hFFFF_7FFF);
    scan("R9");

    repeat (5) @(negedge clk);
    scan("R11");

    for (int k = 0; k < 600; k++) begin
      int a = int'($urandom % (N + 3));
      logic [31:0] d = $urandom;
      if (($urandom % 16) != 0) d[15] = 1'b0;
      wr(a, d);
      if (k % 50 == 49) scan("R2 R4 R5 R6 random");
    end

    do_reset();
    scan("R1 R8 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule